// File: doc/BRIEF.md
# Latched Interrupt Register Unit

This block gathers up to 32 interrupt sources for one functional unit. It raises a single level request toward the chip's interrupt aggregation logic. Each source passes through an enable bit and a mask bit. A rising edge on a source that is enabled and unmasked is latched into an identity register. Software reads that register to find out which sources fired, and clears them by writing ones.

Every identity bit is a two-deep event queue. While a bit is already pending, one more event on that source is held in a hidden second slot. Clearing the bit then exposes the queued event straight away. A full clean-up of an idle unit therefore takes two clear writes, each followed by a read. The unit is shut off by setting every mask bit and writing zero to the enable register.

Four registers are reachable over a simple single-cycle read/write bus: the live source status, the mask, the identity register and the enable register. Read data is registered and appears on the cycle after the read strobe.

Top module: `irq_latch_unit`

## Requirements
- R1: After synchronous reset the mask register reads all ones, the enable register reads zero, the identity register reads zero, `irq_o` is low and `rdata_o` is zero.
- R2: Byte offsets decode as 0x0 status, 0x4 mask, 0x8 identity, 0xC enable. Read data appears on `rdata_o` one cycle after `rd_en_i`. The mask and enable registers read back exactly the last value written.
- R3: The status register (0x0) returns the raw `src_i` value with no latching, and a write to it changes nothing.
- R4: An event is a rising edge of `src_i[i]` while enable bit i is 1 and mask bit i is 0. A source held high produces one event only. An edge that is masked or not enabled latches nothing and is not recalled after unmasking.
- R5: An event on a clear identity bit sets it. An event on a set bit fills that bit's second slot. Further events while both are full are dropped.
- R6: Writing 1 to identity bit i clears it, and bits written with 0 are untouched. If the second slot of bit i is full, the bit reads 1 again after the clear and the slot empties, so two clears empty a doubly queued bit.
- R7: An event arriving in the same cycle as a clear of that bit leaves the bit set, holding the new event.
- R8: `irq_o` is high exactly when any identity bit is set, and changes on the same clock edge as the identity register.
- R9: With every mask bit set and enable zero, no new event latches, while bits already latched stay until cleared.
- R10: Offsets other than the four listed read as zero and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Raw per-source event inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt request toward the aggregator |

## Verification
The bench drives sources that fire two and three times before software reacts. If the second slot were missing, one clear would leave the bit low. If the queue did not saturate, the third event would survive two clears. It holds a source high over many cycles, which would leave a level-sensitive design re-latching after every clear. It lines up an event with a clear of the same bit, which a design that lets the clear win would lose. It also checks that masked edges, disabled edges and edges seen while the unit is shut off are never recalled once the source is opened again, and that partial clears leave the other bits alone.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int OFS_STATUS = 'h0;
  localparam int OFS_MASK   = 'h4;
  localparam int OFS_IDENT  = 'h8;
  localparam int OFS_ENABLE = 'hC;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;

  // R4: a held level yields no second rising edge
  assert_held_no_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((rise_o & $past(src_i)) == '0));
endmodule

// File: rtl/irq_queue_bit.sv
module irq_queue_bit (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o,
  output logic pend_d_o
);
  logic pend_q, extra_q;
  logic pend_d, extra_d;

  always_comb begin
    if (!pend_q) begin
      pend_d  = evt_i;
      extra_d = 1'b0;
    end else if (clr_i) begin
      pend_d  = extra_q | evt_i;
      extra_d = extra_q & evt_i;
    end else begin
      pend_d  = 1'b1;
      extra_d = extra_q | evt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      extra_q <= extra_d;
    end
  end

  assign pend_o   = pend_q;
  assign pend_d_o = pend_d;

  // R5: the second slot is only ever occupied behind a pending bit
  assert_slot_order_R5: assert property (@(posedge clk) disable iff (rst)
    extra_q |-> pend_q);
  // R6: a clear with a queued event leaves the bit pending
  assert_requeue_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && extra_q && clr_i) |=> pend_q);
  // R6: a clear with nothing queued and no new event empties the bit
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !extra_q && clr_i && !evt_i) |=> !pend_q);
  // R7: an event during a clear is kept
  assert_clear_race_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i) |=> pend_q);
endmodule

// File: rtl/irq_latch_unit.sv
module irq_latch_unit
  import irq_unit_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  logic [NSRC-1:0] mask_q, en_q, rdata_q;
  logic [NSRC-1:0] rise, evt, clr, ident_q, ident_d, rd_mux;
  logic            irq_q;

  irq_edge_detect #(.W(NSRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(src_i), .rise_o(rise)
  );

  assign evt = rise & en_q & ~mask_q;
  assign clr = (wr_en_i && addr_i == A_IDENT) ? wdata_i : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    irq_queue_bit u_q (
      .clk(clk), .rst(rst), .evt_i(evt[i]), .clr_i(clr[i]),
      .pend_o(ident_q[i]), .pend_d_o(ident_d[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      en_q   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_MASK)   mask_q <= wdata_i;
      if (addr_i == A_ENABLE) en_q   <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_STATUS: rd_mux = src_i;
      A_MASK:   rd_mux = mask_q;
      A_IDENT:  rd_mux = ident_q;
      A_ENABLE: rd_mux = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rd_mux;
      irq_q <= |ident_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R1: reset leaves the unit fully masked and disabled
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && en_q == '0 && ident_q == '0 && !irq_o));
  // R2: mask reads back what was stored
  assert_mask_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_MASK) |=> (rdata_o == $past(mask_q)));
  // R3: status reads the live inputs
  assert_status_live_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_STATUS) |=> (rdata_o == $past(src_i)));
  // R4: without qualified events or clears the identity register holds
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (evt == '0 && clr == '0) |=> (ident_q == $past(ident_q)));
  // R8: the request line tracks the identity register
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ident_q != '0));
endmodule

// File: tb/tb_irq_latch_unit.sv
`timescale 1ns/1ps
module tb_irq_latch_unit;
  localparam int NSRC = 32;
  localparam int AW   = 4;
  localparam int NV   = 6;

  localparam logic [31:0] T_MASK [NV] = '{32'h0, 32'hFFFF0000, 32'h0, 32'h00FF00FF, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] T_EN   [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFF00FF00, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0] T_SRC  [NV] = '{32'h00000001, 32'h80018001, 32'hFFFF0000, 32'hFFFFFFFF, 32'h12345678, 32'hA5A5A5A5};

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] src = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NSRC-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  irq_latch_unit #(.NSRC(NSRC), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [31:0] b);
    @(negedge clk); src = b;
    @(negedge clk); src = '0;
  endtask

  task automatic flush();
    bus_wr(4'h8, 32'hFFFFFFFF); bus_rd(4'h8, got);
    bus_wr(4'h8, 32'hFFFFFFFF); bus_rd(4'h8, got);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    bus_rd(4'h4, got); check("R1 mask", got, 32'hFFFFFFFF);
    bus_rd(4'hC, got); check("R1 enable", got, 32'h0);
    bus_rd(4'h8, got); check("R1 ident", got, 32'h0);

    // R3 live status, writes ignored
    @(negedge clk); src = 32'h0000005A;
    bus_rd(4'h0, got); check("R3 status", got, 32'h0000005A);
    bus_wr(4'h0, 32'hFFFFFFFF);
    bus_rd(4'h0, got); check("R3 status write ignored", got, 32'h0000005A);
    @(negedge clk); src = '0;

    // R2 readback
    bus_wr(4'h4, 32'h13579BDF); bus_rd(4'h4, got); check("R2 mask", got, 32'h13579BDF);
    bus_wr(4'hC, 32'h2468ACE0); bus_rd(4'hC, got); check("R2 enable", got, 32'h2468ACE0);

    // R10 unmapped offsets
    bus_wr(4'h6, 32'h0); bus_rd(4'h4, got); check("R10 write ignored", got, 32'h13579BDF);
    bus_rd(4'h2, got); check("R10 read zero", got, 32'h0);

    // table walk (R4, R5, R8)
    for (int v = 0; v < NV; v++) begin
      flush();
      bus_wr(4'h4, T_MASK[v]);
      bus_wr(4'hC, T_EN[v]);
      pulse(T_SRC[v]);
      bus_rd(4'h8, got);
      check("R4 table ident", got, T_SRC[v] & T_EN[v] & ~T_MASK[v]);
      check("R8 table irq", {31'b0, irq}, {31'b0, (T_SRC[v] & T_EN[v] & ~T_MASK[v]) != 0});
    end

    // R6 double event needs two clears
    flush();
    bus_wr(4'h4, 32'h0); bus_wr(4'hC, 32'hFFFFFFFF);
    pulse(32'h1); pulse(32'h1);
    bus_wr(4'h8, 32'h1); bus_rd(4'h8, got); check("R6 requeued", got, 32'h1);
    check("R8 irq still high", {31'b0, irq}, 32'h1);
    bus_wr(4'h8, 32'h1); bus_rd(4'h8, got); check("R6 second clear", got, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);

    // R5 third event dropped
    pulse(32'h4); pulse(32'h4); pulse(32'h4);
    bus_wr(4'h8, 32'h4); bus_wr(4'h8, 32'h4);
    bus_rd(4'h8, got); check("R5 saturate", got, 32'h0);

    // R4 held level is one event
    @(negedge clk); src = 32'h2;
    repeat (6) @(negedge clk);
    bus_wr(4'h8, 32'h2);
    bus_rd(4'h8, got); check("R4 held level", got, 32'h0);
    @(negedge clk); src = '0;

    // R4 masked edge not recalled
    bus_wr(4'h4, 32'h00000010); pulse(32'h10);
    bus_rd(4'h8, got); check("R4 masked", got, 32'h0);
    bus_wr(4'h4, 32'h0);
    bus_rd(4'h8, got); check("R4 not recalled", got, 32'h0);

    // R6 partial clear
    pulse(32'h3);
    bus_wr(4'h8, 32'h1); bus_rd(4'h8, got); check("R6 partial", got, 32'h2);
    flush();

    // R7 event during clear
    pulse(32'h8);
    @(negedge clk); wr_en = 1'b1; addr = 4'h8; wdata = 32'h8; src = 32'h8;
    @(negedge clk); wr_en = 1'b0; src = '0;
    bus_rd(4'h8, got); check("R7 race kept", got, 32'h8);
    bus_wr(4'h8, 32'h8); bus_rd(4'h8, got); check("R7 single clear", got, 32'h0);

    // R9 shut off
    pulse(32'h20);
    bus_wr(4'h4, 32'hFFFFFFFF); bus_wr(4'hC, 32'h0);
    pulse(32'h60);
    bus_rd(4'h8, got); check("R9 latched kept", got, 32'h20);
    bus_wr(4'h8, 32'h20); bus_rd(4'h8, got); check("R9 no new", got, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule